// File: doc/BRIEF.md
# Fractional Pixel Clock Divider

This block derives a display pixel clock from a fast interface clock. The period is set by a word in units of the interface clock with four fractional bits, so it has 1/16-clock resolution. Each pixel period is a whole number of interface clocks: either the integer part of the word or one more. A fractional accumulator chooses which, so that the length averaged over many periods equals the programmed value exactly.

The outputs are a pixel clock level, a one-cycle tick that marks the first interface cycle of each pixel period, and a half-cycle flag. When a period has an odd number of cycles, its ideal falling edge lies half an interface clock after the registered one. The flag marks that cycle so that a downstream output stage can place the edge on the opposite clock phase. A new period word is sampled only at the start of a pixel period. Deasserting the enable stops the clock and clears the accumulator, so the next enable starts a fresh sequence.

Top module: `pclk_frac_div`

## Requirements
- R1: While rst_ni is low, and in the first cycle after reset, clk_o, tick_o and half_o are 0.
- R2: In every cycle after a clock edge that sampled en_i low, all three outputs are 0 and the accumulator is cleared. The first edge that samples en_i high starts a new pixel period, and tick_o is 1 in the cycle after that edge.
- R3: Take the word W = period_i, clamped per R6. Its integer part is W[11:4] and its fraction is W[3:0]. At each period start the fraction is added to a 4-bit accumulator. The period lasts W[11:4] + 1 cycles if the sum reaches 16, and W[11:4] cycles otherwise. The accumulator keeps the sum modulo 16.
- R4: With a constant word after enable, 16 consecutive pixel periods span exactly W interface cycles in total, where W is read as an integer in 1/16 units.
- R5: For a word with a zero fraction, every period lasts exactly W[11:4] cycles.
- R6: A word below 0x020 (2.0 clocks) is treated as 0x020, so periods of 2 cycles are produced.
- R7: A change of period_i in the middle of a pixel period does not alter that period. The new word governs the period that starts next.
- R8: clk_o is 1 for the first floor(L/2) cycles of a period of L cycles and 0 for the rest.
- R9: half_o is 1 for exactly one cycle, the first low cycle of a period, when L is odd. It is never 1 when L is even.
- R10: tick_o is 1 in the first cycle of each pixel period and 0 in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Divider enable; low stops output and clears accumulator |
| period_i | input | INT_W+FRAC_W (12) | Period word, unsigned fixed point, 4 fractional bits |
| clk_o | output | 1 | Pixel clock level |
| tick_o | output | 1 | High in the first cycle of each pixel period |
| half_o | output | 1 | Falling edge of this period belongs half a clock later |

## Verification
The bench builds the block with its defaults: 8 integer and 4 fractional bits. With these the whole 1/16 fraction range is covered, and a 16-period window must close to the programmed word exactly. Random words are kept below 16.0 clocks so that many periods fit in a run. These words include values under 2.0 that hit the clamp, pure integers, odd and even lengths, and every fractional pattern. Directed cases change the word in the middle of a period and toggle the enable.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int unsigned PCLK_INT_W  = 8;
  localparam int unsigned PCLK_FRAC_W = 4;
  localparam int unsigned PCLK_MIN_INT = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;
endpackage

// File: rtl/pclk_clamp.sv
module pclk_clamp #(
  parameter int unsigned INT_W   = pclk_pkg::PCLK_INT_W,
  parameter int unsigned FRAC_W  = pclk_pkg::PCLK_FRAC_W,
  parameter int unsigned MIN_INT = pclk_pkg::PCLK_MIN_INT,
  localparam int unsigned PW     = INT_W + FRAC_W
) (
  input  logic [PW-1:0]     word_i,
  output logic [INT_W-1:0]  int_o,
  output logic [FRAC_W-1:0] frac_o
);
  localparam logic [INT_W-1:0] MIN_V = INT_W'(MIN_INT);

  logic [INT_W-1:0] raw_int;

  always_comb begin
    raw_int = word_i[PW-1:FRAC_W];
    if (raw_int < MIN_V) begin
      int_o  = MIN_V;
      frac_o = '0;
    end else begin
      int_o  = raw_int;
      frac_o = word_i[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/pclk_frac_acc.sv
module pclk_frac_acc #(
  parameter int unsigned INT_W  = pclk_pkg::PCLK_INT_W,
  parameter int unsigned FRAC_W = pclk_pkg::PCLK_FRAC_W,
  localparam int unsigned CNT_W = INT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [CNT_W-1:0]  len_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum   = {1'b0, acc_q} + {1'b0, frac_i};
  assign len_o = {1'b0, int_i} + CNT_W'(sum[FRAC_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (!en_i)    acc_q <= '0;
    else if (start_i)  acc_q <= sum[FRAC_W-1:0];
  end

  // carry-in length never shorter than integer part nor more than one longer
  a_r3_len_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (len_o >= {1'b0, int_i}) && (len_o <= {1'b0, int_i} + CNT_W'(1)));

  // fraction zero leaves remainder unchanged
  a_r5_int_no_drift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && start_i && frac_i == '0) |=> $stable(acc_q));
endmodule

// File: rtl/pclk_phase_gen.sv
module pclk_phase_gen #(
  parameter int unsigned INT_W  = pclk_pkg::PCLK_INT_W,
  localparam int unsigned CNT_W = INT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             start_o,
  output logic             clk_o,
  output logic             tick_o,
  output logic             half_o
);
  import pclk_pkg::*;

  logic [CNT_W-1:0] idx_q, len_q;
  logic             active_q;
  logic [CNT_W-1:0] hi_len;
  phase_e           phase;

  assign hi_len  = len_q >> 1;
  assign start_o = en_i && (!active_q || (idx_q == len_q - CNT_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      len_q    <= '0;
    end else if (!en_i) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (start_o) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      len_q    <= len_i;
    end else begin
      idx_q    <= idx_q + CNT_W'(1);
    end
  end

  always_comb begin
    if (!active_q)            phase = PH_IDLE;
    else if (idx_q < hi_len)  phase = PH_HIGH;
    else                      phase = PH_LOW;
  end

  assign clk_o  = (phase == PH_HIGH);
  assign tick_o = active_q && (idx_q == '0);
  assign half_o = (phase == PH_LOW) && len_q[0] && (idx_q == hi_len);

  a_r10_tick_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> clk_o);

  a_r9_half_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_o |-> (!clk_o && !tick_o && $fell(clk_o)));

  a_r2_idle_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!clk_o && !tick_o && !half_o));

  a_r6_min_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (len_q >= CNT_W'(2)));

  a_r7_len_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !tick_o) |-> $stable(len_q));
endmodule

// File: rtl/pclk_frac_div.sv
module pclk_frac_div #(
  parameter int unsigned INT_W  = pclk_pkg::PCLK_INT_W,
  parameter int unsigned FRAC_W = pclk_pkg::PCLK_FRAC_W,
  localparam int unsigned PW    = INT_W + FRAC_W,
  localparam int unsigned CNT_W = INT_W + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [PW-1:0] period_i,
  output logic          clk_o,
  output logic          tick_o,
  output logic          half_o
);
  logic [INT_W-1:0]  int_w;
  logic [FRAC_W-1:0] frac_w;
  logic [CNT_W-1:0]  len_w;
  logic              start_w;

  pclk_clamp #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_clamp (
    .word_i (period_i),
    .int_o  (int_w),
    .frac_o (frac_w)
  );

  pclk_frac_acc #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .start_i (start_w),
    .int_i   (int_w),
    .frac_i  (frac_w),
    .len_o   (len_w)
  );

  pclk_phase_gen #(.INT_W(INT_W)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .len_i   (len_w),
    .start_o (start_w),
    .clk_o   (clk_o),
    .tick_o  (tick_o),
    .half_o  (half_o)
  );

  a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!clk_o && !tick_o && !half_o));
endmodule

// File: tb/pclk_frac_div_tb.sv
module pclk_frac_div_tb_top;
  localparam int unsigned PW = 12;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en = 1'b0;
  logic [PW-1:0] word = '0;
  logic          clk_o, tick_o, half_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference state
  bit m_active; int m_idx, m_len, m_acc;
  longint cyc = 0, last_tick = -1, first_tick, tick17;
  int ticks, len_min, len_max, last_len;

  always #2 clk = ~clk;

  pclk_frac_div dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .period_i(word),
    .clk_o(clk_o), .tick_o(tick_o), .half_o(half_o)
  );

  function automatic int clamp_w(int w);
    return (w < 32) ? 32 : w;
  endfunction

  task automatic chk(bit ok, string req, int got, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s got %0d expected %0d (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  task automatic model_edge(bit e, int w);
    if (!e) begin
      m_active = 0; m_idx = 0; m_acc = 0;
    end else if (!m_active || m_idx == m_len - 1) begin
      int cw, s;
      cw = clamp_w(w);
      s = m_acc + (cw % 16);
      m_len = cw / 16 + ((s >= 16) ? 1 : 0);
      m_acc = s % 16;
      m_idx = 0;
      m_active = 1;
    end else m_idx++;
  endtask

  task automatic step();
    bit e_tick, e_clk, e_half;
    @(posedge clk);
    model_edge(en, int'(word));
    @(negedge clk);
    cyc++;
    e_tick = m_active && m_idx == 0;
    e_clk  = m_active && m_idx < m_len / 2;
    e_half = m_active && (m_len % 2 == 1) && m_idx == m_len / 2;
    if (!en) begin
      chk(!clk_o && !tick_o && !half_o, "R2", {clk_o, tick_o, half_o}, 0);
    end else begin
      chk(tick_o == e_tick, "R10", tick_o, e_tick);
      chk(clk_o == e_clk, "R8", clk_o, e_clk);
      chk(half_o == e_half, "R9", half_o, e_half);
    end
    if (tick_o) begin
      if (last_tick >= 0) begin
        last_len = int'(cyc - last_tick);
        if (last_len < len_min) len_min = last_len;
        if (last_len > len_max) len_max = last_len;
      end
      ticks++;
      if (ticks == 1) first_tick = cyc;
      if (ticks == 17) tick17 = cyc;
      last_tick = cyc;
    end
  endtask

  task automatic clear_meas();
    ticks = 0; last_tick = -1; len_min = 1 << 30; len_max = 0;
  endtask

  // constant-word segment: restart, run 16 periods, check total span
  task automatic run_seg(int w);
    int cw;
    en = 0;
    step(); step();
    word = PW'(w);
    en = 1;
    clear_meas();
    step();
    chk(tick_o == 1'b1, "R2", tick_o, 1);
    while (ticks < 17) step();
    cw = clamp_w(w);
    chk(tick17 - first_tick == cw, "R4", int'(tick17 - first_tick), cw);
    if (w < 32) chk(len_max == 2 && len_min == 2, "R6", len_max, 2);
    if (cw % 16 == 0)
      chk(len_min == cw / 16 && len_max == cw / 16, "R5", len_max, cw / 16);
    else
      chk(len_min == cw / 16 && len_max == cw / 16 + 1, "R3", len_max, cw / 16 + 1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    m_active = 0; m_idx = 0; m_len = 0; m_acc = 0;
    clear_meas();

    repeat (3) @(negedge clk);
    chk(!clk_o && !tick_o && !half_o, "R1", {clk_o, tick_o, half_o}, 0);
    rst_ni = 1'b1;
    word = 12'h0A8;
    step();
    chk(!clk_o && !tick_o && !half_o, "R1", {clk_o, tick_o, half_o}, 0);
    repeat (3) step();

    run_seg('h020);
    run_seg('h030);
    run_seg('h018);
    run_seg('h000);
    run_seg('h0A8);
    run_seg('h05F);
    run_seg('h021);
    run_seg('h050);
    run_seg('h0FF);

    // R7: mid-period change keeps the current length
    en = 0; step();
    word = 12'h0A0; en = 1;
    clear_meas();
    step();
    repeat (3) step();
    word = 12'h030;
    while (ticks < 3) step();
    chk(len_min == 10 || len_max == 10, "R7", len_max, 10);
    chk(len_min == 3, "R7", len_min, 3);

    // R2: disable mid-period then restart
    en = 0; step(); step();
    en = 1; word = 12'h049;
    clear_meas();
    step();
    chk(tick_o == 1'b1, "R2", tick_o, 1);

    // random mix
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 19) == 0) word = PW'($urandom_range(0, 255));
      en = ($urandom_range(0, 99) != 0);
      step();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule